// File: doc/BRIEF.md
# IF Frequency Counter with Acceptance Window

This block checks whether an intermediate-frequency signal sits on its expected frequency. A reference clock is divided by a programmable prescaler into a base tick. The tick is then stretched by a power-of-two divider into a gate whose length comes from a sample-time field. During each gate, a down-counter that was preloaded with the expected number of IF cycles loses one count on every rising edge of the IF input. When the gate closes, the residue shows how far the real count was from the target. The result is reported on a one-cycle done pulse and a held valid flag.

The expected count per base tick depends on the mode: FM, AM, or AM with up-conversion to a 10.7 MHz IF. The count is fixed per mode by a parameter, scaled by the gate length, and moved by a signed centre-adjust field. A window field sets how many IF cycles of error are still accepted. The counter runs at one of two lengths, chosen from the preload value. Gates follow each other without a break for as long as a mode other than off is selected. The IF input must already be synchronous to the reference clock.

Top module: `if_freq_counter`

## Requirements
- R1: While rst_ni is low and after it rises, done_o and valid_o are 0 until a measurement completes.
- R2: With mode_i = 2'b00 no measurement runs: done_o never pulses, and valid_o goes to 0 one cycle after 2'b00 is applied.
- R3: A gate lasts (presc_i + 1) * 2^samp_i reference cycles. The first gate begins in the cycle after a mode other than off is applied, and later gates follow back to back. done_o is therefore high in cycle G+1 after the mode is applied, and every G cycles after that.
- R4: done_o is high for exactly one cycle at the end of each gate (for presc_i > 0).
- R5: The preload is P = (C + cf_i) * 2^samp_i. Here cf_i is a 5-bit two's-complement value, and C is FM_CYC for mode 2'b01, AM_CYC for 2'b10 and UPC_CYC for 2'b11. With win_i = 0, valid_o is 1 only if exactly P rising edges of if_i fell inside the gate.
- R6: With k rising edges in the gate, valid_o is 1 exactly when |k - P| <= win_i (win_i is 3 bits, 0..7). This holds whether k is above or below P.
- R7: The counter has a length of SHORT_W bits when P < 2^SHORT_W - 8, and CNT_W bits otherwise. Edge counts that differ from P by a multiple of 2^length alias to the same result.
- R8: valid_o changes only at the edge that raises done_o, or when the mode is turned off. It keeps its value between measurements.
- R9: Only rising edges of if_i are counted. A level held high across cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_i | input | 1 | IF signal, synchronous to clk_i |
| mode_i | input | 2 | 00 off, 01 FM, 10 AM, 11 AM up-conversion |
| presc_i | input | PRESC_W | Prescaler terminal value; the tick period is presc_i+1 cycles |
| samp_i | input | 3 | Gate length exponent, 2^samp_i ticks |
| win_i | input | 3 | Accepted error in IF cycles |
| cf_i | input | 5 | Signed centre adjust added to the per-tick count |
| done_o | output | 1 | One-cycle pulse at the end of a gate |
| valid_o | output | 1 | Result of the last finished gate |

## Verification
A wrong tick or tap count in the gate timer moves done_o off the cycle G+1 / G cadence. That shows at the first or second pulse after the mode is set. A wrong preload, centre adjust or length choice inverts valid_o for edge counts placed at P, at P±win_i, at P±(win_i+1) or at P+2^SHORT_W. That shows at the done of the gate which contained those edges. A judgement or reload fault shows either when valid_o drifts between pulses or when an idle second gate fails to report 0.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_FM  = 2'b01,
    MODE_AM  = 2'b10,
    MODE_UPC = 2'b11
  } ifc_mode_e;
endpackage

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int PRESC_W = 14,
  parameter int SAMP_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [SAMP_W-1:0]  samp_i,
  output logic               gate_end_o
);
  localparam int TC_W = (2 ** SAMP_W) - 1;

  logic [PRESC_W-1:0] pc_q;
  logic [TC_W-1:0]    tc_q;
  logic [TC_W-1:0]    tc_lim;
  logic               tick;

  // terminal tick count = 2^samp - 1, built as a thermometer
  for (genvar i = 0; i < TC_W; i++) begin : g_tap
    assign tc_lim[i] = (SAMP_W'(i) < samp_i);
  end

  assign tick       = run_i && (pc_q == presc_i);
  assign gate_end_o = tick && (tc_q == tc_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (!run_i) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
      tc_q <= gate_end_o ? '0 : tc_q + 1'b1;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ifc_preload.sv
module ifc_preload
  import ifc_pkg::*;
#(
  parameter int CNT_W   = 21,
  parameter int SHORT_W = 11,
  parameter int CF_W    = 5,
  parameter int SAMP_W  = 3,
  parameter int FM_CYC  = 1712,
  parameter int AM_CYC  = 450,
  parameter int UPC_CYC = 10700
) (
  input  logic [1:0]        mode_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [CF_W-1:0]   cf_i,
  output logic [CNT_W-1:0]  preload_o,
  output logic [CNT_W-1:0]  mask_o
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] SHORT_LIM  = CNT_W'((2 ** SHORT_W) - 8);
  localparam logic [CNT_W-1:0] SHORT_MASK = CNT_W'((2 ** SHORT_W) - 1);
  localparam logic [CNT_W-1:0] FULL_MASK  = '1;

  logic signed [SUM_W-1:0] base_s, cf_s, sum_s;
  logic [CNT_W-1:0]        per_tick;

  always_comb begin
    unique case (ifc_mode_e'(mode_i))
      MODE_FM:  base_s = SUM_W'(FM_CYC);
      MODE_AM:  base_s = SUM_W'(AM_CYC);
      MODE_UPC: base_s = SUM_W'(UPC_CYC);
      default:  base_s = '0;
    endcase
  end

  assign cf_s     = {{(SUM_W-CF_W){cf_i[CF_W-1]}}, cf_i};
  assign sum_s    = base_s + cf_s;
  assign per_tick = sum_s[SUM_W-1] ? '0 : sum_s[CNT_W-1:0];

  assign preload_o = per_tick << samp_i;
  assign mask_o    = (preload_o < SHORT_LIM) ? SHORT_MASK : FULL_MASK;
endmodule

// File: rtl/ifc_main_cnt.sv
module ifc_main_cnt #(
  parameter int CNT_W = 21,
  parameter int WIN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             if_i,
  input  logic             gate_end_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             valid_o
);
  logic             if_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q, cnt_dec, tol;
  logic             in_win;

  assign rise    = if_i && !if_q;
  assign cnt_dec = (cnt_q - CNT_W'(rise)) & mask_i;
  assign tol     = CNT_W'(win_i);
  // residue near zero: short count; near all-ones: count overshot
  assign in_win  = (cnt_dec <= tol) || (cnt_dec > (mask_i - tol));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_q    <= 1'b0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if_q   <= if_i;
      done_o <= gate_end_i;
      if (start_i || gate_end_i) cnt_q <= preload_i;
      else if (run_i)            cnt_q <= cnt_dec;
      if (!run_i)          valid_o <= 1'b0;
      else if (gate_end_i) valid_o <= in_win;
    end
  end
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter
  import ifc_pkg::*;
#(
  parameter int PRESC_W = 14,
  parameter int CNT_W   = 21,
  parameter int SHORT_W = 11,
  parameter int FM_CYC  = 1712,
  parameter int AM_CYC  = 450,
  parameter int UPC_CYC = 10700
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               if_i,
  input  logic [1:0]         mode_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [2:0]         samp_i,
  input  logic [2:0]         win_i,
  input  logic [4:0]         cf_i,
  output logic               done_o,
  output logic               valid_o
);
  logic             mode_on, run_q, run_eff, start, gate_end;
  logic [CNT_W-1:0] preload, mask, cnt;

  assign mode_on = (ifc_mode_e'(mode_i) != MODE_OFF);
  assign run_eff = run_q && mode_on;
  assign start   = mode_on && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= mode_on;
  end

  ifc_gate_timer #(.PRESC_W(PRESC_W), .SAMP_W(3)) i_gate (
    .clk_i, .rst_ni,
    .run_i     (run_eff),
    .presc_i,
    .samp_i,
    .gate_end_o(gate_end)
  );

  ifc_preload #(
    .CNT_W(CNT_W), .SHORT_W(SHORT_W), .CF_W(5), .SAMP_W(3),
    .FM_CYC(FM_CYC), .AM_CYC(AM_CYC), .UPC_CYC(UPC_CYC)
  ) i_pre (
    .mode_i, .samp_i, .cf_i,
    .preload_o(preload),
    .mask_o   (mask)
  );

  ifc_main_cnt #(.CNT_W(CNT_W), .WIN_W(3)) i_cnt (
    .clk_i, .rst_ni,
    .run_i     (run_eff),
    .start_i   (start),
    .if_i,
    .gate_end_i(gate_end),
    .preload_i (preload),
    .mask_i    (mask),
    .win_i,
    .cnt_o     (cnt),
    .done_o,
    .valid_o
  );
endmodule

// File: rtl/ifc_chk.sv
module ifc_chk #(
  parameter int PRESC_W = 14,
  parameter int CNT_W   = 21
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic [PRESC_W-1:0] presc_i,
  input logic               done_o,
  input logic               valid_o,
  input logic               gate_end_i,
  input logic               run_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W-1:0]   mask_i
);
  // R2
  mode_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (!done_o && !valid_o));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && presc_i != '0) |=> !done_o);

  // R3
  done_at_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(gate_end_i));

  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !gate_end_i) |=> $stable(valid_o));

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= mask_i));
endmodule

bind if_freq_counter ifc_chk #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) i_ifc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .presc_i   (presc_i),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .gate_end_i(gate_end),
  .run_i     (run_eff),
  .cnt_i     (cnt),
  .mask_i    (mask)
);

// File: tb/test_if_freq_counter.sv
module test_if_freq_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int FM_C  = 40;
  localparam int AM_C  = 10;
  localparam int UPC_C = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_s = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [13:0] presc = 14'd299;
  logic [2:0]  samp = '0, win = '0;
  logic [4:0]  cf = '0;
  logic        done, valid;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  if_freq_counter #(.FM_CYC(FM_C), .AM_CYC(AM_C), .UPC_CYC(UPC_C)) i_if_freq_counter (
    .clk_i(clk), .rst_ni(rst_n), .if_i(if_s), .mode_i(mode), .presc_i(presc),
    .samp_i(samp), .win_i(win), .cf_i(cf), .done_o(done), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic setup(input logic [1:0] m, input int p, input int s,
                       input int w, input int c);
    @(negedge clk); mode = 2'b00; if_s = 1'b0;
    repeat (3) @(negedge clk);
    presc = 14'(p); samp = 3'(s); win = 3'(w); cf = 5'(c);
    @(negedge clk); mode = m;
  endtask

  task automatic pulses(input int k);
    repeat (2) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      if_s = 1'b1; @(negedge clk);
      if_s = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    while (!done && t < 30000) begin @(negedge clk); t++; end
    seen = done;
  endtask

  task automatic measure(input logic [1:0] m, input int p, input int s, input int w,
                         input int c, input int k, input bit exp, input string req);
    bit seen;
    setup(m, p, s, w, c);
    pulses(k);
    wait_done(seen);
    check(seen, req, "done seen", int'(seen), 1);
    check(valid == exp, req, $sformatf("valid k=%0d", k), int'(valid), int'(exp));
  endtask

  task automatic t_reset;
    check(!done && !valid, "R1", "flags in reset", {done, valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !valid, "R1", "flags after reset", {done, valid}, 0);
  endtask

  task automatic t_off;
    bit any = 0;
    measure(2'b01, 299, 0, 0, 0, FM_C, 1'b1, "R2");
    @(negedge clk); mode = 2'b00;
    @(negedge clk);
    check(!valid, "R2", "valid cleared by off", int'(valid), 0);
    for (int i = 0; i < 400; i++) begin
      if_s = ~if_s; @(negedge clk);
      if (done || valid) any = 1;
    end
    if_s = 1'b0;
    check(!any, "R2", "no activity while off", int'(any), 0);
  endtask

  task automatic t_period;
    int t = 0;
    setup(2'b01, 9, 2, 0, 0);
    while (!done && t < 1000) begin @(negedge clk); t++; end
    check(t == 41, "R3", "first done cycle", t, 41);
    @(negedge clk);
    check(!done, "R4", "done width", int'(done), 0);
    t = 1;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    check(t == 40, "R3", "gate period", t, 40);
  endtask

  task automatic t_hold;
    bit bad = 0, seen;
    measure(2'b01, 299, 0, 0, 0, FM_C, 1'b1, "R8");
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!valid || done) bad = 1;
    end
    check(!bad, "R8", "valid held between dones", int'(bad), 0);
    wait_done(seen);
    check(seen && !valid, "R8", "idle gate reports invalid", int'(valid), 0);
  endtask

  task automatic t_level;
    bit seen;
    setup(2'b10, 299, 0, 0, 0);
    pulses(AM_C - 1);
    if_s = 1'b1; repeat (20) @(negedge clk); if_s = 1'b0;
    wait_done(seen);
    check(seen && valid, "R9", "held level counts once", int'(valid), 1);
  endtask

  initial begin
    t_reset();
    t_off();
    t_period();
    // R5 exact counts per mode, window 0
    measure(2'b01, 299, 0, 0, 0, FM_C,      1'b1, "R5");
    measure(2'b01, 299, 0, 0, 0, FM_C + 1,  1'b0, "R5");
    measure(2'b10, 299, 0, 0, 0, AM_C,      1'b1, "R5");
    measure(2'b10, 299, 0, 0, 0, FM_C,      1'b0, "R5");
    measure(2'b11, 299, 0, 0, 0, UPC_C,     1'b1, "R5");
    measure(2'b01, 299, 2, 0, 0, FM_C * 4,  1'b1, "R5");
    measure(2'b01, 299, 0, 0, 3, FM_C + 3,  1'b1, "R5");
    measure(2'b01, 299, 0, 0, 3, FM_C,      1'b0, "R5");
    measure(2'b01, 299, 0, 0, -4, FM_C - 4, 1'b1, "R5");
    // R6 window edges on both sides
    measure(2'b01, 299, 0, 1, 0, FM_C + 1,  1'b1, "R6");
    measure(2'b01, 299, 0, 1, 0, FM_C - 1,  1'b1, "R6");
    measure(2'b01, 299, 0, 2, 0, FM_C - 3,  1'b0, "R6");
    measure(2'b01, 299, 0, 3, 0, FM_C - 3,  1'b1, "R6");
    measure(2'b01, 299, 2, 7, 0, 150,       1'b0, "R6");
    measure(2'b01, 299, 2, 7, 0, 153,       1'b1, "R6");
    measure(2'b01, 299, 2, 7, 0, 167,       1'b1, "R6");
    t_hold();
    t_level();
    // R7 short length aliases, long length does not
    measure(2'b01, 399, 5, 0, 0, FM_C * 32 + 2048,  1'b1, "R7");
    measure(2'b11, 399, 5, 0, 0, UPC_C * 32 + 2048, 1'b0, "R7");
    measure(2'b11, 399, 5, 0, 0, UPC_C * 32,        1'b1, "R7");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule